// File: doc/BRIEF.md
# Block Register-List Transfer Sequencer

This block turns one block-load or block-store request into a stream of memory beats for the load-store pipeline. A single-cycle start pulse presents a 16-bit register list, a base byte address and a load/store select. The block then issues one beat per clock until every register in the list has moved. Registers go out in ascending index order. Each beat carries up to two register indices and the byte address it starts at.

A beat moves two registers whenever its address is 64-bit aligned (address bit 2 clear). If the base is only word aligned (bit 2 set), the first beat moves a single register so that every later beat is aligned. While beats are being issued, an ALU-stall output holds the ALU execute stage. The stall drops once the last memory beat has finished.

In the cycle after the last beat, a one-cycle done pulse appears together with the final address (base plus four per register), which the core can use for base writeback. An empty list finishes without any beat and without stalling the ALU.

Top module: `lsm_xfer_seq`

## Requirements
- R1: While reset is asserted and after it is released, `beat_valid`, `alu_stall` and `done` are all low until a start is accepted.
- R2: A start pulse with a non-empty list, seen while no transfer is running, produces its first beat in the next cycle at `beat_addr` equal to `base_addr`. `beat_is_load` equals the captured `is_load` on every beat.
- R3: Registers are issued in strictly ascending index order. The lowest index still pending is always in slot 0. Slot 0 is valid on every beat.
- R4: On a beat whose address has bit 2 clear, slot 1 carries the next pending index above slot 0. Slot 1 is empty only when no other register is pending.
- R5: On a beat whose address has bit 2 set, only slot 0 is used.
- R6: Each beat's address equals the previous beat's address plus 4 for each register the previous beat moved.
- R7: A list of n registers takes ceil(n/2) beats from an aligned base and 1 + floor(n/2) beats from a misaligned base. As a result, 2k-1 and 2k registers take the same number of beats when aligned.
- R8: `alu_stall` is high in every beat cycle and low in the done cycle and while idle.
- R9: `done` is high for exactly the one cycle after the last beat. In that cycle `final_addr` equals the base plus 4 times the number of registers in the list, and `beat_valid` is low.
- R10: A start with an empty list raises `done` in the next cycle, with `final_addr` equal to the base. It issues no beat and no stall.
- R11: A start pulse that arrives while beats are being issued is ignored. The running transfer continues unchanged, and no new transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| reg_mask | input | 16 | Register list, bit i selects register i |
| base_addr | input | 32 | Byte base address, word aligned |
| is_load | input | 1 | 1 for a load, 0 for a store |
| beat_valid | output | 1 | A memory beat is issued this cycle |
| beat_is_load | output | 1 | Direction of the current beat |
| beat_addr | output | 32 | Byte address of the current beat |
| slot0_valid | output | 1 | Slot 0 carries a register |
| slot0_idx | output | 4 | Register index in slot 0 |
| slot1_valid | output | 1 | Slot 1 carries a register |
| slot1_idx | output | 4 | Register index in slot 1 |
| alu_stall | output | 1 | Holds the ALU execute stage |
| done | output | 1 | One-cycle end-of-transfer pulse |
| final_addr | output | 32 | Address after the last register, valid with done |

## Verification
The bench runs a misaligned base with an even count and another with an odd count. A design that forgot the single-register first beat would pair registers across a 64-bit boundary and finish one beat early. Equal-beat pairs such as three and four aligned registers catch a design that counts beats as the number of registers. Sparse lists with gaps expose a design that steps indices by one instead of hunting for the next set bit. An empty list catches a design that issues a phantom beat or stalls the ALU. A start injected mid-transfer catches a design that restarts or corrupts the running list.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned LSM_NREG_DEF = 16;
  localparam int unsigned LSM_AW_DEF   = 32;
  localparam int unsigned LSM_WORD_B   = 4;
  typedef enum logic {ST_IDLE = 1'b0, ST_BEAT = 1'b1} lsm_state_e;
endpackage

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lsm_beat_plan.sv
module lsm_beat_plan #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic          misal,
  output logic          s0_v,
  output logic [IW-1:0] s0_idx,
  output logic          s1_v,
  output logic [IW-1:0] s1_idx,
  output logic [N-1:0]  pend_next,
  output logic [1:0]    nregs
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  clr0, clr1, pend_a;
  logic          f1;
  logic [IW-1:0] i1;

  lsm_lowbit #(.N(N), .IW(IW)) u_first (.vec(pend), .found(s0_v), .idx(s0_idx));

  always_comb begin
    clr0   = s0_v ? (ONE << s0_idx) : '0;
    pend_a = pend & ~clr0;
  end

  lsm_lowbit #(.N(N), .IW(IW)) u_second (.vec(pend_a), .found(f1), .idx(i1));

  always_comb begin
    s1_v      = f1 & ~misal;
    s1_idx    = i1;
    clr1      = s1_v ? (ONE << i1) : '0;
    pend_next = pend_a & ~clr1;
    nregs     = {1'b0, s0_v} + {1'b0, s1_v};
  end
endmodule

// File: rtl/lsm_xfer_seq.sv
module lsm_xfer_seq
  import lsm_pkg::*;
#(
  parameter int unsigned NREG = LSM_NREG_DEF,
  parameter int unsigned AW   = LSM_AW_DEF,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0] base_addr,
  input  logic          is_load,
  output logic          beat_valid,
  output logic          beat_is_load,
  output logic [AW-1:0] beat_addr,
  output logic          slot0_valid,
  output logic [IW-1:0] slot0_idx,
  output logic          slot1_valid,
  output logic [IW-1:0] slot1_idx,
  output logic          alu_stall,
  output logic          done,
  output logic [AW-1:0] final_addr
);
  localparam int unsigned ALIGN_BIT = $clog2(2 * LSM_WORD_B) - 1;

  lsm_state_e      state_q, state_n;
  logic [NREG-1:0] pend_q, pend_n;
  logic [AW-1:0]   addr_q, addr_n;
  logic            load_q, load_n;
  logic            done_q, done_n;

  logic            p_s0_v, p_s1_v;
  logic [IW-1:0]   p_s0_idx, p_s1_idx;
  logic [NREG-1:0] p_next;
  logic [1:0]      p_nregs;

  lsm_beat_plan #(.N(NREG), .IW(IW)) u_plan (
    .pend(pend_q), .misal(addr_q[ALIGN_BIT]),
    .s0_v(p_s0_v), .s0_idx(p_s0_idx), .s1_v(p_s1_v), .s1_idx(p_s1_idx),
    .pend_next(p_next), .nregs(p_nregs)
  );

  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    addr_n  = addr_q;
    load_n  = load_q;
    done_n  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start) begin
        pend_n = reg_mask;
        addr_n = base_addr;
        load_n = is_load;
        if (reg_mask == '0) done_n = 1'b1;
        else                state_n = ST_BEAT;
      end
    end else begin
      pend_n = p_next;
      addr_n = addr_q + AW'({p_nregs, 2'b00});
      if (p_next == '0) begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      addr_q  <= addr_n;
      load_q  <= load_n;
      done_q  <= done_n;
    end
  end

  always_comb begin
    beat_valid   = (state_q == ST_BEAT);
    beat_is_load = load_q;
    beat_addr    = addr_q;
    slot0_valid  = beat_valid & p_s0_v;
    slot0_idx    = p_s0_idx;
    slot1_valid  = beat_valid & p_s1_v;
    slot1_idx    = p_s1_idx;
    alu_stall    = beat_valid;
    done         = done_q;
    final_addr   = addr_q;
  end
endmodule

// File: rtl/lsm_xfer_seq_chk.sv
module lsm_xfer_seq_chk #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat_valid,
  input logic [AW-1:0] beat_addr,
  input logic          slot0_valid,
  input logic [IW-1:0] slot0_idx,
  input logic          slot1_valid,
  input logic [IW-1:0] slot1_idx,
  input logic          alu_stall,
  input logic          done
);
  assert_slot0_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> slot0_valid);

  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_valid |-> (slot1_idx > slot0_idx));

  assert_beat_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> (slot0_idx > $past(slot0_idx)));

  assert_misal_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_addr[2]) |-> !slot1_valid);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |->
      (beat_addr == $past(beat_addr) + ($past(slot1_valid) ? AW'(8) : AW'(4))));

  assert_stall_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!alu_stall && !beat_valid));

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beat_valid) |-> done);
endmodule

bind lsm_xfer_seq lsm_xfer_seq_chk #(.NREG(NREG), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_addr(beat_addr),
  .slot0_valid(slot0_valid), .slot0_idx(slot0_idx), .slot1_valid(slot1_valid),
  .slot1_idx(slot1_idx), .alu_stall(alu_stall), .done(done)
);

// File: tb/sim_lsm_xfer_seq.sv
module sim_lsm_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [31:0] base_addr = '0;
  logic        is_load = 1'b0;
  logic        beat_valid, beat_is_load, slot0_valid, slot1_valid, alu_stall, done;
  logic [31:0] beat_addr, final_addr;
  logic [3:0]  slot0_idx, slot1_idx;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lsm_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask),
    .base_addr(base_addr), .is_load(is_load), .beat_valid(beat_valid),
    .beat_is_load(beat_is_load), .beat_addr(beat_addr), .slot0_valid(slot0_valid),
    .slot0_idx(slot0_idx), .slot1_valid(slot1_valid), .slot1_idx(slot1_idx),
    .alu_stall(alu_stall), .done(done), .final_addr(final_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int lowest(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  task automatic run_xfer(input logic [15:0] m, input logic [31:0] b,
                          input logic ld, input bit inject);
    logic [15:0] rem;
    logic [31:0] a;
    int beats, n, expb, lo, hi;
    @(negedge clk);
    start = 1'b1; reg_mask = m; base_addr = b; is_load = ld;
    @(negedge clk);
    start = 1'b0; reg_mask = 16'hA5A5; base_addr = 32'hDEAD_0000; is_load = ~ld;
    rem = m; a = b; beats = 0; n = $countones(m);
    while (rem != 0 && beats < 20) begin
      chk("R2 beat_valid", beat_valid, 1);
      chk("R2 beat_is_load", beat_is_load, ld);
      chk("R8 alu_stall", alu_stall, 1);
      chk("R6 beat_addr", beat_addr, a);
      lo = lowest(rem); rem[lo] = 1'b0;
      chk("R3 slot0_valid", slot0_valid, 1);
      chk("R3 slot0_idx", slot0_idx, lo);
      if (!a[2] && rem != 0) begin
        hi = lowest(rem); rem[hi] = 1'b0;
        chk("R4 slot1_valid", slot1_valid, 1);
        chk("R4 slot1_idx", slot1_idx, hi);
        a = a + 8;
      end else begin
        chk(a[2] ? "R5 slot1_valid" : "R4 slot1_valid", slot1_valid, 0);
        a = a + 4;
      end
      beats++;
      if (inject && beats == 1) begin
        start = 1'b1; reg_mask = 16'h00F0; base_addr = 32'h0000_2000;  // R11
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (n == 0) expb = 0;
    else if (b[2]) expb = 1 + n / 2;
    else expb = (n + 1) / 2;
    chk("R7 beat count", beats, expb);
    chk(n == 0 ? "R10 done" : "R9 done", done, 1);
    chk(n == 0 ? "R10 beat_valid" : "R9 beat_valid", beat_valid, 0);
    chk(n == 0 ? "R10 alu_stall" : "R8 alu_stall", alu_stall, 0);
    chk(n == 0 ? "R10 final_addr" : "R9 final_addr", final_addr, b + 32'(4 * n));
    @(negedge clk);
    chk("R9 done width", done, 0);
    chk("R11 no late start", beat_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 beat_valid in reset", beat_valid, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 beat_valid", beat_valid, 0);
    chk("R1 alu_stall", alu_stall, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_aligned;
    run_xfer(16'hFFFF, 32'h0000_1000, 1'b1, 1'b0);  // R4 full list
    run_xfer(16'h0007, 32'h0000_1000, 1'b0, 1'b0);  // R7 three regs
    run_xfer(16'h000F, 32'h0000_1000, 1'b1, 1'b0);  // R7 four regs
    run_xfer(16'h8421, 32'h0000_3008, 1'b0, 1'b0);  // R3 sparse
  endtask

  task automatic t_misaligned;
    run_xfer(16'h000F, 32'h0000_1004, 1'b1, 1'b0);  // R5 even count
    run_xfer(16'h0007, 32'h0000_1004, 1'b0, 1'b0);  // R5 odd count
    run_xfer(16'h8000, 32'h0000_100C, 1'b1, 1'b0);  // R5 single
    run_xfer(16'hF0F0, 32'h0000_4004, 1'b0, 1'b0);  // R6
  endtask

  task automatic t_empty;
    run_xfer(16'h0000, 32'h0000_5554, 1'b1, 1'b0);  // R10
  endtask

  task automatic t_busy_start;
    run_xfer(16'h0F0F, 32'h0000_6000, 1'b1, 1'b1);  // R11
  endtask

  initial begin
    #2;
    t_reset();
    t_aligned();
    t_misaligned();
    t_empty();
    t_busy_start();
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule